// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns the single-bit output of a sigma-delta modulator into signed multi-bit conversion results. It is a cascaded-integrator-comb filter of order three. The integrators run on every modulator sample, which is marked by a clock enable. The differentiators run once per output period. The decimation ratio is eight times an 8-bit scale word, so the output rate is the modulator rate divided by (8 × scale). With a nominal 32.768 kHz modulator, a scale of 3 gives about 1365 Hz and a scale of 255 gives about 16 Hz. The magnitude response is the cube of a sinc, which puts notches at every whole multiple of the output rate.

The block also tracks settling. Reset or a restart pulse (for example on a channel change) clears all filter state. The result-valid strobe is then held low until the third decimated output. That is the first output whose window lies entirely after the restart. A new scale word is staged and only takes effect at the next restart, so a running conversion never mixes two ratios.

Top module: `sinc3_decimator`

## Requirements
- R1: A sample is taken only in a cycle with `sample_en` high. Bit value 1 counts as +1 and bit value 0 counts as −1. `mod_bit` is ignored in cycles with `sample_en` low.
- R2: After reset or restart, one decimated output is formed every 8 × S accepted samples, where S is the active scale word.
- R3: Each output equals the triple cascaded moving sum (window length 8 × S, zero history before the restart) of the ±1 samples, evaluated at the sample that completes the output period. This is a sinc-cubed response.
- R4: After reset or restart, the first two decimated outputs are withheld. The first `result_vld` strobe comes with the output formed at accepted sample 3 × 8 × S.
- R5: Out of reset, the active and staged scale words are both 69 (a ratio of 552).
- R6: A written scale value below 3 is stored as 3.
- R7: A pulse on `scale_wr` stages `scale_wdata` without changing the running ratio. The staged value becomes active at the next `restart`. If `scale_wr` and `restart` arrive in the same cycle, the newly written value is the one that becomes active.
- R8: `restart` clears the integrator, comb and phase state and restarts the settling count. A sample enabled in the same cycle as `restart` is discarded. No strobe follows a restart cycle.
- R9: `result_vld` is a one-cycle pulse. It rises in the cycle after the edge that accepts the completing sample. `result` changes only with that pulse and holds its value until the next pulse.
- R10: The 35-bit result covers full scale at scale 255 without wrapping. All-ones input gives +2040³ and all-zeros input gives −2040³.
- R11: During and right after reset, `result_vld` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_en | input | 1 | Modulator-rate enable: one accepted sample per high cycle |
| mod_bit | input | 1 | Modulator bitstream |
| scale_wdata | input | 8 | Scale word to stage |
| scale_wr | input | 1 | Stage `scale_wdata` this cycle |
| restart | input | 1 | Synchronous restart: clear filter state, apply staged scale |
| result | output | 35 | Signed settled conversion result |
| result_vld | output | 1 | One-cycle strobe marking a new settled result |

## Verification
Two functions can fall in the same cycle: a restart and an enabled sample that would complete an output period. The bench provokes this by driving exactly one sample short of a period boundary and then pulsing `restart` with `sample_en` still high. It then expects no strobe and a fresh settling count. A second coincidence is a scale write that lands in the same cycle as a restart. The following outputs are judged against a reference built with the newly written ratio, not the previously staged one. The scoreboard's reference is a triple moving sum, computed separately for every accepted sample.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int SCALE_W      = 8;
  localparam int SUM_W        = 35;
  localparam int SCALE_RESET  = 69;
  localparam int SCALE_FLOOR  = 3;
  localparam int RATIO_SHIFT  = 3;   // ratio = scale * 2**RATIO_SHIFT
  localparam int FILT_ORDER   = 3;
  localparam int SETTLE_OUTS  = 3;
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
  parameter int SCALE_W     = sinc3_pkg::SCALE_W,
  parameter int SCALE_RESET = sinc3_pkg::SCALE_RESET,
  parameter int SCALE_FLOOR = sinc3_pkg::SCALE_FLOOR,
  parameter int RATIO_SHIFT = sinc3_pkg::RATIO_SHIFT,
  parameter int SETTLE_OUTS = sinc3_pkg::SETTLE_OUTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic               restart,
  input  logic               scale_wr,
  input  logic [SCALE_W-1:0] scale_wdata,
  output logic               take_sample,
  output logic               dec_tick,
  output logic               settled
);
  localparam int PH_W  = SCALE_W + RATIO_SHIFT;
  localparam int CNT_W = $clog2(SETTLE_OUTS + 1);
  localparam logic [SCALE_W-1:0] FLOOR_V = SCALE_W'(SCALE_FLOOR);
  localparam logic [SCALE_W-1:0] RESET_V = SCALE_W'(SCALE_RESET);
  localparam logic [CNT_W-1:0]   LAST_C  = CNT_W'(SETTLE_OUTS - 1);

  logic [SCALE_W-1:0] pend_q, pend_n, act_q, act_n, wr_val;
  logic [PH_W-1:0]    phase_q, phase_n, phase_last;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               at_end;

  always_comb begin
    wr_val      = (scale_wdata < FLOOR_V) ? FLOOR_V : scale_wdata;
    phase_last  = {act_q, {RATIO_SHIFT{1'b0}}} - PH_W'(1);
    at_end      = (phase_q == phase_last);
    take_sample = sample_en && !restart;
    dec_tick    = take_sample && at_end;
    settled     = (cnt_q == LAST_C);
  end

  always_comb begin
    pend_n  = scale_wr ? wr_val : pend_q;
    act_n   = act_q;
    phase_n = phase_q;
    cnt_n   = cnt_q;
    if (restart) begin
      act_n   = pend_n;
      phase_n = '0;
      cnt_n   = '0;
    end else if (sample_en) begin
      phase_n = at_end ? '0 : phase_q + PH_W'(1);
      if (at_end && (cnt_q != LAST_C))
        cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= RESET_V;
      act_q   <= RESET_V;
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      pend_q  <= pend_n;
      act_q   <= act_n;
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end

  // R6: the running scale never drops below the floor
  a_r6_scale_floor: assert property (@(posedge clk) disable iff (!rst_n)
    act_q >= FLOOR_V);
  // R2: the phase counter stays inside the current output period
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < {act_q, {RATIO_SHIFT{1'b0}}});
  // R4: settling count never exceeds its saturation value
  a_r4_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int SUM_W = sinc3_pkg::SUM_W,
  parameter int ORDER = sinc3_pkg::FILT_ORDER
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_sample,
  input  logic                    clear,
  input  logic                    mod_bit,
  output logic signed [SUM_W-1:0] sum_next
);
  logic signed [SUM_W-1:0] chain [0:ORDER];

  // bit 1 -> +1, bit 0 -> -1
  assign chain[0] = mod_bit ? SUM_W'(1) : {SUM_W{1'b1}};

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic signed [SUM_W-1:0] acc_q, acc_n;
    assign chain[g+1] = acc_q + chain[g];

    always_comb begin
      acc_n = acc_q;
      if (clear)            acc_n = '0;
      else if (take_sample) acc_n = chain[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_n;
    end
  end

  assign sum_next = chain[ORDER];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int SUM_W = sinc3_pkg::SUM_W,
  parameter int ORDER = sinc3_pkg::FILT_ORDER
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_tick,
  input  logic                    clear,
  input  logic signed [SUM_W-1:0] sum_in,
  output logic signed [SUM_W-1:0] diff_out
);
  logic signed [SUM_W-1:0] chain [0:ORDER];
  assign chain[0] = sum_in;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic signed [SUM_W-1:0] dly_q, dly_n;
    assign chain[g+1] = chain[g] - dly_q;

    always_comb begin
      dly_n = dly_q;
      if (clear)         dly_n = '0;
      else if (dec_tick) dly_n = chain[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_n;
    end
  end

  assign diff_out = chain[ORDER];
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
  parameter int SCALE_W     = sinc3_pkg::SCALE_W,
  parameter int SUM_W       = sinc3_pkg::SUM_W,
  parameter int SCALE_RESET = sinc3_pkg::SCALE_RESET,
  parameter int SCALE_FLOOR = sinc3_pkg::SCALE_FLOOR,
  parameter int RATIO_SHIFT = sinc3_pkg::RATIO_SHIFT,
  parameter int ORDER       = sinc3_pkg::FILT_ORDER,
  parameter int SETTLE_OUTS = sinc3_pkg::SETTLE_OUTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic               mod_bit,
  input  logic [SCALE_W-1:0] scale_wdata,
  input  logic               scale_wr,
  input  logic               restart,
  output logic [SUM_W-1:0]   result,
  output logic               result_vld
);
  logic take_sample, dec_tick, settled;
  logic signed [SUM_W-1:0] sum_next, diff;
  logic [SUM_W-1:0] res_q, res_n;
  logic             vld_q, vld_n;

  sinc3_ctrl #(
    .SCALE_W(SCALE_W), .SCALE_RESET(SCALE_RESET), .SCALE_FLOOR(SCALE_FLOOR),
    .RATIO_SHIFT(RATIO_SHIFT), .SETTLE_OUTS(SETTLE_OUTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .restart(restart),
    .scale_wr(scale_wr), .scale_wdata(scale_wdata),
    .take_sample(take_sample), .dec_tick(dec_tick), .settled(settled)
  );

  sinc3_integ #(.SUM_W(SUM_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_n(rst_n), .take_sample(take_sample), .clear(restart),
    .mod_bit(mod_bit), .sum_next(sum_next)
  );

  sinc3_comb #(.SUM_W(SUM_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst_n(rst_n), .dec_tick(dec_tick), .clear(restart),
    .sum_in(sum_next), .diff_out(diff)
  );

  always_comb begin
    res_n = res_q;
    vld_n = 1'b0;
    if (dec_tick && settled) begin
      res_n = diff;
      vld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_n;
      vld_q <= vld_n;
    end
  end

  assign result     = res_q;
  assign result_vld = vld_q;

  // R9: strobe lasts exactly one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);
  // R9: result only moves together with the strobe
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> $stable(result));
  // R8: nothing is reported right after a restart
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !result_vld);
  // R1: a strobe always follows an enabled sample
  a_r1_vld_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> $past(sample_en));
endmodule

// File: tb/sinc3_decimator_test.sv
`timescale 1ns/1ps
module sinc3_decimator_test;
  localparam int SUM_W = 35;
  localparam int MAXN  = 8400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0, mod_bit = 1'b0, scale_wr = 1'b0, restart = 1'b0;
  logic [7:0] scale_wdata = 8'd0;
  logic [SUM_W-1:0] result;
  logic result_vld;

  always #2 clk = ~clk;

  sinc3_decimator uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mod_bit(mod_bit),
    .scale_wdata(scale_wdata), .scale_wr(scale_wr), .restart(restart),
    .result(result), .result_vld(result_vld)
  );

  int checks = 0, errors = 0;
  longint exp_q[$];
  string  tag_q[$];

  // reference model state
  int     ratio = 552, pend = 69, n = 0;
  longint xs[0:MAXN], m1s[0:MAXN], m2s[0:MAXN];
  longint m3 = 0;

  function automatic int clampv(int v);
    return (v < 3) ? 3 : v;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic model_sample(bit b, string tag);
    longint x, m1, m2;
    n++;
    x  = b ? 1 : -1;
    xs[n] = x;
    m1 = ((n > 1) ? m1s[n-1] : 0) + x - ((n > ratio) ? xs[n-ratio] : 0);
    m1s[n] = m1;
    m2 = ((n > 1) ? m2s[n-1] : 0) + m1 - ((n > ratio) ? m1s[n-ratio] : 0);
    m2s[n] = m2;
    m3 = m3 + m2 - ((n > ratio) ? m2s[n-ratio] : 0);
    if ((n % ratio == 0) && (n / ratio >= 3)) begin
      exp_q.push_back(m3);
      tag_q.push_back(tag);
    end
  endtask

  // one clock of stimulus; inputs change 1 ns after the rising edge
  task automatic drive(bit en, bit b, bit rs, bit wr, int val, string tag);
    @(posedge clk);
    #1;
    sample_en   = en;
    mod_bit     = b;
    restart     = rs;
    scale_wr    = wr;
    scale_wdata = val[7:0];
    if (wr) pend = clampv(val);
    if (rs) begin
      ratio = 8 * pend;
      n = 0;
      m3 = 0;
    end else if (en) begin
      model_sample(b, tag);
    end
  endtask

  // mode: 0 random, 1 all ones, 2 all zeros, 3 pattern 1100; gap adds idle cycles
  task automatic run(int count, int mode, bit gap, string tag);
    for (int i = 0; i < count; i++) begin
      bit b;
      case (mode)
        1: b = 1'b1;
        2: b = 1'b0;
        3: b = (i % 4) < 2;
        default: b = 1'($urandom);
      endcase
      drive(1'b1, b, 1'b0, 1'b0, 0, tag);
      if (gap) drive(1'b0, 1'($urandom), 1'b0, 1'b0, 0, "R1");
    end
  endtask

  // scoreboard monitor
  bit prev_vld = 1'b0;
  longint prev_res = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      longint act;
      act = longint'($signed(result));
      if (prev_vld)
        check(!result_vld && act == prev_res, "R9", act, prev_res);
      if (result_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected strobe", act, 0);
        end else begin
          longint e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(act == e, t, act, e);
        end
      end
      prev_vld = result_vld;
      prev_res = act;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    check(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(result_vld == 1'b0, "R11 vld in reset", longint'(result_vld), 0);
    check(result == '0, "R11 result in reset", longint'(result), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(result_vld == 1'b0, "R11 vld after reset", longint'(result_vld), 0);
    check(result == '0, "R11 result after reset", longint'(result), 0);

    // R5: default scale 69 -> ratio 552, four periods
    run(4 * 552, 0, 1'b0, "R5");
    // R7: write and restart together -> scale 5 active; R1 idle cycles
    drive(1'b1, 1'b1, 1'b1, 1'b1, 5, "R7");
    run(5 * 40, 0, 1'b1, "R3");
    // R6: value 1 clamps to 3 (ratio 24)
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1, "R6");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 0, "R6");
    run(6 * 24, 3, 1'b0, "R6");
    // R7: staged write does not change running ratio
    drive(1'b0, 1'b0, 1'b0, 1'b1, 7, "R7");
    run(3 * 24, 0, 1'b0, "R7 staged");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 0, "R7");
    run(4 * 56, 0, 1'b0, "R7 applied");
    // R4: restart mid-settling, then exactly three periods -> one result
    drive(1'b0, 1'b0, 1'b1, 1'b0, 0, "R4");
    run(100, 0, 1'b0, "R4");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 0, "R4");
    run(3 * 56, 0, 1'b0, "R4");
    // R8: restart coinciding with the sample that would close a period
    run(56 - 1, 0, 1'b0, "R8");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 0, "R8");
    run(3 * 56, 0, 1'b0, "R8");
    // R2: smallest ratio with constant input
    drive(1'b1, 1'b0, 1'b1, 1'b1, 3, "R2");
    run(5 * 24, 1, 1'b1, "R2");
    // R10: full scale at scale 255, both polarities
    drive(1'b0, 1'b0, 1'b1, 1'b1, 255, "R10");
    run(4 * 2040, 1, 1'b0, "R10");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 0, "R10");
    run(3 * 2040, 2, 1'b0, "R10");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0, "idle");
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R4 missing strobes", longint'(exp_q.size()), 0);
    finish_run();
  end
endmodule